// File: doc/BRIEF.md
# Windowed Mean-Square Power Monitor

This block estimates the average power of one or two sample streams. Each cycle it takes the magnitude of each signed input sample, squares it, and adds the square to a per-channel accumulator. A down-counter sets the length of the measurement window. When the counter reaches its last count, each channel's sum is normalised by a right shift and copied into a holding register. The accumulator then clears and the next window begins with no gap.

The shift amount is the ceiling of log2 of the window length. The result is therefore the exact mean only when the window length is a power of two, and host software applies the correction for other lengths. Square root and logarithmic conversion are also left to software.

A complex mode treats channel A as the in-phase part and channel B as the quadrature part. In that mode the channel A result reports the combined power I²+Q², while channel B keeps reporting its own power. An enable input gates the whole monitor. While it is low, the block holds its counters cleared and uses no accumulation activity.

Top module: `pwr_mon`

## Requirements
- R1: After reset, `res_a` and `res_b` are zero and `res_valid` is low.
- R2: Samples are signed two's complement. The magnitude of a sample is its absolute value, except that the most negative code saturates to 2^(SAMPLE_W-1)-1. The square of that magnitude is accumulated once per counted cycle.
- R3: Once `enable` is high, the first cycle only loads the window length from `period` and counts no sample. Each later window covers exactly `period` consecutive samples, with a `period` of 0 treated as 1. Windows follow one another with no gap.
- R4: A result equals floor(sum / 2^ceil(log2 P)) shifted right by (2·(SAMPLE_W-1) − RESULT_W) bits, where P is the window length. If that value does not fit in RESULT_W bits, the result saturates to all ones.
- R5: `res_valid` is high in the cycle after the edge that takes a window's last sample, and the new results appear in that same cycle. While `res_valid` is low, both results hold their values.
- R6: When `complex_mode` is 1, `res_a` reports the sum of a² + b² (magnitudes as in R2) and `res_b` reports b² alone. When `complex_mode` is 0, `res_a` reports a² alone.
- R7: A change to `period` partway through a window does not alter that window. The new length applies from the next reload.
- R8: While `enable` is low, `res_valid` stays low and the results hold. A partial window in progress is discarded, and raising `enable` again starts over with a load cycle.
- R9: Each window's sum starts from zero, so no sample counts in two windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the monitor when high |
| complex_mode | input | 1 | 1: channel A reports I²+Q² |
| period | input | PERIOD_W | Window length in samples (0 acts as 1) |
| samp_a | input | SAMPLE_W | Channel A sample, signed |
| samp_b | input | SAMPLE_W | Channel B sample, signed |
| res_a | output | RESULT_W | Channel A holding register |
| res_b | output | RESULT_W | Channel B holding register |
| res_valid | output | 1 | One-cycle pulse on each holding update |

## Verification
The bench builds the block with SAMPLE_W=6, PERIOD_W=4 and RESULT_W=8. With this configuration every window length from 0 to 15 can be swept in both modes. The sweep covers every shift amount from 0 to 4, both exact and inexact power-of-two normalisation, the saturated most-negative sample, and complex sums large enough to clip the 8-bit result. The bench also runs back-to-back windows with a period change partway through a window, and drops enable during a partial window.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;

    typedef struct packed {
        logic load;
        logic dump;
    } win_tick_t;

    function automatic logic [5:0] ceil_log2(input logic [31:0] p);
        logic [5:0] r;
        logic       found;
        r     = 6'd32;
        found = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (!found && ((64'd1 << i) >= {32'd0, p})) begin
                r     = 6'(i);
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pwr_mon_sq.sv
module pwr_mon_sq #(
    parameter int SAMPLE_W = 14,
    localparam int MAG_W = SAMPLE_W - 1,
    localparam int SQ_W  = 2 * MAG_W
) (
    input  logic signed [SAMPLE_W-1:0] samp,
    output logic        [SQ_W-1:0]     sq
);
    logic [SAMPLE_W-1:0] neg;
    logic [MAG_W-1:0]    mag;

    always_comb begin
        neg = ~samp + 1'b1;
        if (samp[SAMPLE_W-1]) begin
            mag = neg[SAMPLE_W-1] ? {MAG_W{1'b1}} : neg[MAG_W-1:0];
        end else begin
            mag = samp[MAG_W-1:0];
        end
        sq = SQ_W'(mag) * SQ_W'(mag);
    end
endmodule

// File: rtl/pwr_mon_timer.sv
module pwr_mon_timer
    import pwr_mon_pkg::*;
#(
    parameter int PERIOD_W = 24,
    localparam int SH_W = $clog2(PERIOD_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output win_tick_t           tk,
    output logic [SH_W-1:0]     shift
);
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] p_eff;
    logic [SH_W-1:0]     sh_next;

    always_comb begin
        p_eff   = (period == '0) ? PERIOD_W'(1) : period;
        sh_next = SH_W'(ceil_log2(32'(p_eff)));
        tk.load = enable && (cnt == '0);
        tk.dump = enable && (cnt == PERIOD_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt   <= '0;
            shift <= '0;
        end else if (cnt == '0 || cnt == PERIOD_W'(1)) begin
            cnt   <= p_eff;
            shift <= sh_next;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
        (enable && cnt == PERIOD_W'(1)) |=> (cnt == $past(p_eff))); // R7
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0)); // R8
endmodule

// File: rtl/pwr_mon_acc.sv
module pwr_mon_acc
    import pwr_mon_pkg::*;
#(
    parameter int IN_W     = 27,
    parameter int ACC_W    = 51,
    parameter int RESULT_W = 20,
    parameter int DROP     = 6,
    parameter int SH_W     = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  win_tick_t           tk,
    input  logic [SH_W-1:0]     shift,
    input  logic [IN_W-1:0]     sq_in,
    output logic [RESULT_W-1:0] hold
);
    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    tot;
    logic [ACC_W-1:0]    scaled;
    logic [RESULT_W-1:0] sat;

    always_comb begin
        tot    = acc + ACC_W'(sq_in);
        scaled = (tot >> shift) >> DROP;
        sat    = (|scaled[ACC_W-1:RESULT_W]) ? {RESULT_W{1'b1}} : scaled[RESULT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || tk.load || tk.dump) begin
            acc <= '0;
        end else begin
            acc <= tot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (tk.dump) begin
            hold <= sat;
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        tk.dump |=> (acc == '0)); // R9
endmodule

// File: rtl/pwr_mon.sv
module pwr_mon
    import pwr_mon_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int PERIOD_W = 24,
    parameter int RESULT_W = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       complex_mode,
    input  logic [PERIOD_W-1:0]        period,
    input  logic signed [SAMPLE_W-1:0] samp_a,
    input  logic signed [SAMPLE_W-1:0] samp_b,
    output logic [RESULT_W-1:0]        res_a,
    output logic [RESULT_W-1:0]        res_b,
    output logic                       res_valid
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam int SQ_W  = 2 * MAG_W;
    localparam int IN_W  = SQ_W + 1;
    localparam int ACC_W = IN_W + PERIOD_W;
    localparam int DROP  = SQ_W - RESULT_W;
    localparam int SH_W  = $clog2(PERIOD_W + 1);

    win_tick_t           tk;
    logic [SH_W-1:0]     shift;
    logic [SQ_W-1:0]     sq [2];
    logic [IN_W-1:0]     feed [2];
    logic [RESULT_W-1:0] hold [2];

    pwr_mon_sq #(.SAMPLE_W(SAMPLE_W)) u_sq_a (.samp(samp_a), .sq(sq[0]));
    pwr_mon_sq #(.SAMPLE_W(SAMPLE_W)) u_sq_b (.samp(samp_b), .sq(sq[1]));

    always_comb begin
        feed[0] = complex_mode ? (IN_W'(sq[0]) + IN_W'(sq[1])) : IN_W'(sq[0]);
        feed[1] = IN_W'(sq[1]);
    end

    pwr_mon_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst(rst), .enable(enable), .period(period),
        .tk(tk), .shift(shift)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ch
        pwr_mon_acc #(
            .IN_W(IN_W), .ACC_W(ACC_W), .RESULT_W(RESULT_W),
            .DROP(DROP), .SH_W(SH_W)
        ) u_acc (
            .clk(clk), .rst(rst), .enable(enable), .tk(tk),
            .shift(shift), .sq_in(feed[g]), .hold(hold[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= tk.dump;
        end
    end

    assign res_a = hold[0];
    assign res_b = hold[1];

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!res_valid && res_a == '0 && res_b == '0)); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_a) && $stable(res_b))); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !res_valid); // R8
endmodule

// File: tb/sim_pwr_mon.sv
`timescale 1ns/1ps
module sim_pwr_mon;
    localparam int SW = 6;
    localparam int PW = 4;
    localparam int RW = 8;
    localparam int MAXM = (1 << (SW - 1)) - 1;
    localparam int DROP = 2 * (SW - 1) - RW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic complex_mode = 1'b0;
    logic [PW-1:0] period = '0;
    logic signed [SW-1:0] samp_a = '0;
    logic signed [SW-1:0] samp_b = '0;
    logic [RW-1:0] res_a, res_b;
    logic res_valid;

    int errors = 0;
    int checks = 0;
    int sum_a, sum_b;
    int last_a = 0, last_b = 0;

    always #2 clk = ~clk;

    pwr_mon #(.SAMPLE_W(SW), .PERIOD_W(PW), .RESULT_W(RW)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .complex_mode(complex_mode),
        .period(period), .samp_a(samp_a), .samp_b(samp_b),
        .res_a(res_a), .res_b(res_b), .res_valid(res_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int magsq(input int x);
        int m;
        m = (x < 0) ? -x : x;
        if (m > MAXM) m = MAXM;
        return m * m;
    endfunction

    function automatic int clog(input int p);
        int i = 0;
        while ((1 << i) < p) i++;
        return i;
    endfunction

    function automatic int expect_res(input int sum, input int p);
        int v;
        v = (sum >> clog(p)) >> DROP;
        return (v > (1 << RW) - 1) ? (1 << RW) - 1 : v;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int pat_a(input int k, input int seed, input int p);
        if (seed == 2) return -(1 << (SW - 1));
        return ((k * 13 + seed * 29 + p * 5) % 64) - 32;
    endfunction

    function automatic int pat_b(input int k, input int seed);
        if (seed == 2) return -(1 << (SW - 1));
        return ((k * 7 + seed * 11 + 3) % 64) - 32;
    endfunction

    // Drives n samples; checks valid stays low except after the last one, then checks results.
    task automatic feed(input int n, input int seed, input int p, input int pe, input string tag);
        sum_a = 0;
        sum_b = 0;
        for (int k = 1; k <= n; k++) begin
            int a, b;
            a = pat_a(k, seed, p);
            b = pat_b(k, seed);
            samp_a = SW'(a);
            samp_b = SW'(b);
            sum_a += complex_mode ? magsq(a) + magsq(b) : magsq(a);
            sum_b += magsq(b);
            step();
            if (k < n && n > 1) chk({tag, " R3 no early valid"}, int'(res_valid), 0);
        end
        chk({tag, " R5 valid after window"}, int'(res_valid), 1);
        last_a = expect_res(sum_a, pe);
        last_b = expect_res(sum_b, pe);
        chk({tag, complex_mode ? " R6 res_a complex" : " R2 R4 res_a"}, int'(res_a), last_a);
        chk({tag, " R4 R6 res_b"}, int'(res_b), last_b);
    endtask

    task automatic start(input int p);
        enable = 1'b0;
        period = PW'(p);
        step();
        chk("R8 off: no valid", int'(res_valid), 0);
        chk("R8 off: res_a held", int'(res_a), last_a);
        enable = 1'b1;
        step();
        chk("R3 load cycle no valid", int'(res_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        chk("R1 reset res_a", int'(res_a), 0);
        chk("R1 reset res_b", int'(res_b), 0);
        chk("R1 reset valid", int'(res_valid), 0);
        rst = 1'b0;
        step();
        chk("R1 after reset valid", int'(res_valid), 0);

        // Sweep of every period, both modes, three patterns (R2 R3 R4 R6)
        for (int cx = 0; cx < 2; cx++) begin
            for (int p = 0; p < 16; p++) begin
                for (int seed = 0; seed < 3; seed++) begin
                    int pe;
                    pe = (p == 0) ? 1 : p;
                    complex_mode = cx[0];
                    start(p);
                    feed(pe, seed, p, pe, "sweep");
                end
            end
        end

        // Back-to-back windows, period change mid-window (R7 R9)
        complex_mode = 1'b0;
        start(4);
        feed(4, 0, 4, 4, "b2b w1 R9");
        samp_a = SW'(5);
        samp_b = SW'(-3);
        step();
        period = PW'(6);
        sum_a = 25; sum_b = 9;
        for (int k = 2; k <= 4; k++) begin
            samp_a = SW'(k * 4);
            samp_b = SW'(-k * 5);
            sum_a += magsq(k * 4);
            sum_b += magsq(-k * 5);
            step();
        end
        chk("R7 old length kept valid", int'(res_valid), 1);
        chk("R7 R9 old length res_a", int'(res_a), expect_res(sum_a, 4));
        chk("R9 res_b", int'(res_b), expect_res(sum_b, 4));
        feed(6, 1, 6, 6, "R7 new length");

        // Disable during a partial window (R8)
        start(8);
        for (int k = 0; k < 3; k++) begin
            samp_a = SW'(31);
            samp_b = SW'(31);
            step();
        end
        enable = 1'b0;
        step();
        chk("R8 partial discarded valid", int'(res_valid), 0);
        chk("R8 partial res_a held", int'(res_a), last_a);
        step();
        chk("R8 still quiet", int'(res_valid), 0);
        enable = 1'b1;
        step();
        chk("R8 reload cycle", int'(res_valid), 0);
        feed(8, 0, 8, 8, "R8 restart");
        step();
        chk("R5 pulse ends", int'(res_valid), 0);
        chk("R5 res_a holds", int'(res_a), last_a);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule